// File: doc/BRIEF.md
# End-to-End Flit Integrity Guard with Timeout Recovery

This block guards single flits across a network-on-chip from end to end. On the sending side it takes a 128-bit flit from the local node, adds an 8-bit CRC and a 1-bit sequence tag, and offers it to the network. It keeps a copy and starts a timeout counter. If no matching acknowledgement returns in time, it asks the voltage controller to raise the supply on the route, tagging the request with the sending and receiving node IDs. Once the controller accepts the request, it sends the saved copy again.

On the receiving side the block recomputes the CRC of each arriving flit. A flit that fails the check is dropped without any reply, so recovery always goes through the sender's timeout. A flit that passes is acknowledged with its sequence tag. It is handed to the local node only if its tag is the one expected. A repeat of an already delivered flit, which arrives when an acknowledgement was lost, is acknowledged again but not delivered a second time.

The sending and receiving halves sit in one module and share only the clock and reset. A node instantiates the block once and wires its transmit side toward the network and its receive side from the network. The acknowledgement ports of both halves are brought out so that they can be carried over the return path.

Top module: `e2e_flit_guard`

## Requirements
- R1: The CRC uses generator 0x9B (x^8+x^7+x^4+x^3+x+1), starts from 0x00, has no final inversion, and is taken over the 128 data bits most significant bit first. `net_tx_crc` always equals the CRC of `net_tx_data`, so data 0x1 gives 0x9B and data 0x0 gives 0x00.
- R2: Only one flit is outstanding. `src_in_ready` is high only when nothing is outstanding, and a flit offered while one is outstanding is not taken.
- R3: While `net_tx_valid` is high and `net_tx_ready` is low, the offered data, CRC and tag stay unchanged and valid stays high.
- R4: The tag `net_tx_seq` is 0 for the first flit after reset and inverts after each acknowledged flit. An acknowledgement counts only if `ack_in_seq` equals the outstanding tag; any other acknowledgement is ignored.
- R5: If no matching acknowledgement arrives, `vraise_req` rises exactly TIMEOUT cycles after the clock edge on which the flit left the sender. The request carries `vraise_src` = NODE_ID and `vraise_dst` = the destination given with the flit.
- R6: `vraise_req` stays high, with stable IDs, until `vraise_ack`. In the next cycle the same flit is offered again. The timeout count starts from zero again at the edge where the resent copy leaves.
- R7: A received flit whose CRC does not match is dropped: no acknowledgement and no delivery.
- R8: A received flit with a good CRC and the expected tag is delivered on `dst_out_*` and acknowledged with a one-cycle `ack_out_valid` pulse carrying its tag. Both appear one cycle after acceptance. The expected tag starts at 0 and inverts after each delivery.
- R9: A received flit with a good CRC and an unexpected tag is acknowledged with its tag but not delivered.
- R10: While a delivered flit waits for `dst_out_ready`, `net_rx_ready` is low and `dst_out_data` holds.
- R11: During and after reset, `src_in_ready` and `net_rx_ready` are high and `net_tx_valid`, `vraise_req`, `ack_out_valid` and `dst_out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in_valid | input | 1 | Local node offers a flit |
| src_in_ready | output | 1 | Sender can take a flit |
| src_in_data | input | DATA_W | Flit payload |
| src_in_dest | input | ID_W | Destination node ID of the flit |
| net_tx_valid | output | 1 | Protected flit offered to the network |
| net_tx_ready | input | 1 | Network takes the flit |
| net_tx_data | output | DATA_W | Outgoing payload |
| net_tx_crc | output | 8 | Outgoing CRC |
| net_tx_seq | output | 1 | Outgoing sequence tag |
| ack_in_valid | input | 1 | Acknowledgement returned from the far end |
| ack_in_seq | input | 1 | Tag of the returned acknowledgement |
| vraise_req | output | 1 | Request to raise route voltage |
| vraise_src | output | ID_W | Source node ID of the failing route |
| vraise_dst | output | ID_W | Destination node ID of the failing route |
| vraise_ack | input | 1 | Voltage controller accepted the request |
| net_rx_valid | input | 1 | Flit arriving from the network |
| net_rx_ready | output | 1 | Receiver can take a flit |
| net_rx_data | input | DATA_W | Arriving payload |
| net_rx_crc | input | 8 | Arriving CRC |
| net_rx_seq | input | 1 | Arriving sequence tag |
| dst_out_valid | output | 1 | Checked flit for the local node |
| dst_out_ready | input | 1 | Local node takes the flit |
| dst_out_data | output | DATA_W | Delivered payload |
| ack_out_valid | output | 1 | Acknowledgement pulse toward the sender |
| ack_out_seq | output | 1 | Tag being acknowledged |

## Verification
An accepted source flit appears on the transmit side one cycle later. An accepted receive flit yields its delivery and acknowledgement one cycle later. A voltage request rises exactly TIMEOUT cycles after the transmit handshake edge, and a resend is offered one cycle after the request is accepted. The bench drives inputs on falling edges and compares every output with a behavioural model one nanosecond after each rising edge. Its directed checks count falling edges from each handshake so that they sample in the first cycle where the result is due and in the cycle just before it.

// File: rtl/e2e_guard_pkg.sv
package e2e_guard_pkg;
  localparam int          CRC_W    = 8;
  localparam logic [7:0]  CRC_POLY = 8'h9B;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_WAIT  = 2'd2,
    TX_RAISE = 2'd3
  } tx_state_e;
endpackage

// File: rtl/e2e_crc8.sv
module e2e_crc8 #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0]                data,
  output logic [e2e_guard_pkg::CRC_W-1:0]  crc
);
  import e2e_guard_pkg::*;

  logic [CRC_W-1:0] acc;
  logic             fb;

  // serial division unrolled, most significant data bit enters first
  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ data[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc = acc;
  end
endmodule

// File: rtl/e2e_rst_sync.sv
module e2e_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/e2e_sender.sv
module e2e_sender #(
  parameter int DATA_W  = 128,
  parameter int ID_W    = 6,
  parameter int NODE_ID = 5,
  parameter int TIMEOUT = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [DATA_W-1:0]                 in_data,
  input  logic [ID_W-1:0]                   in_dest,
  output logic                              tx_valid,
  input  logic                              tx_ready,
  output logic [DATA_W-1:0]                 tx_data,
  output logic [e2e_guard_pkg::CRC_W-1:0]   tx_crc,
  output logic                              tx_seq,
  input  logic                              ack_valid,
  input  logic                              ack_seq,
  output logic                              raise_req,
  output logic [ID_W-1:0]                   raise_src,
  output logic [ID_W-1:0]                   raise_dst,
  input  logic                              raise_ack
);
  import e2e_guard_pkg::*;

  localparam int               TMR_W    = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  tx_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_in;
  logic [ID_W-1:0]   dest_q;
  logic              seq_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              load_en, seq_flip, tmr_clr, tmr_inc;

  e2e_crc8 #(.DATA_W(DATA_W)) u_crc (.data(in_data), .crc(crc_in));

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    seq_flip = 1'b0;
    tmr_clr  = 1'b0;
    tmr_inc  = 1'b0;
    unique case (state_q)
      TX_IDLE: if (in_valid) begin
        load_en = 1'b1;
        state_d = TX_SEND;
      end
      TX_SEND: if (tx_ready) begin
        tmr_clr = 1'b1;
        state_d = TX_WAIT;
      end
      TX_WAIT: begin
        if (ack_valid && (ack_seq == seq_q)) begin
          seq_flip = 1'b1;
          state_d  = TX_IDLE;
        end else if (tmr_q == TMR_LAST) begin
          state_d  = TX_RAISE;
        end else begin
          tmr_inc  = 1'b1;
        end
      end
      TX_RAISE: if (raise_ack) state_d = TX_SEND;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      seq_q   <= 1'b0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (seq_flip)     seq_q <= ~seq_q;
      if (tmr_clr)      tmr_q <= '0;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end
  end

  // payload copy: enable only, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= in_data;
      crc_q  <= crc_in;
      dest_q <= in_dest;
    end
  end

  assign in_ready  = (state_q == TX_IDLE);
  assign tx_valid  = (state_q == TX_SEND);
  assign tx_data   = data_q;
  assign tx_crc    = crc_q;
  assign tx_seq    = seq_q;
  assign raise_req = (state_q == TX_RAISE);
  assign raise_src = ID_W'(NODE_ID);
  assign raise_dst = dest_q;
endmodule

// File: rtl/e2e_receiver.sv
module e2e_receiver #(
  parameter int DATA_W = 128
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_valid,
  output logic                             rx_ready,
  input  logic [DATA_W-1:0]                rx_data,
  input  logic [e2e_guard_pkg::CRC_W-1:0]  rx_crc,
  input  logic                             rx_seq,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [DATA_W-1:0]                out_data,
  output logic                             ack_valid,
  output logic                             ack_seq
);
  import e2e_guard_pkg::*;

  logic [CRC_W-1:0]  crc_calc;
  logic [DATA_W-1:0] data_q;
  logic              oval_q, oval_d;
  logic              exp_q, exp_d;
  logic              ackv_q, acks_q;
  logic              take, crc_ok, fresh, deliver, ack_d;

  e2e_crc8 #(.DATA_W(DATA_W)) u_crc (.data(rx_data), .crc(crc_calc));

  always_comb begin
    take    = rx_valid && !oval_q;
    crc_ok  = (crc_calc == rx_crc);
    fresh   = (rx_seq == exp_q);
    ack_d   = take && crc_ok;
    deliver = ack_d && fresh;
    exp_d   = exp_q ^ deliver;
    if (deliver)        oval_d = 1'b1;
    else if (out_ready) oval_d = 1'b0;
    else                oval_d = oval_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oval_q <= 1'b0;
      exp_q  <= 1'b0;
      ackv_q <= 1'b0;
      acks_q <= 1'b0;
    end else begin
      oval_q <= oval_d;
      exp_q  <= exp_d;
      ackv_q <= ack_d;
      if (ack_d) acks_q <= rx_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (deliver) data_q <= rx_data;
  end

  assign rx_ready  = !oval_q;
  assign out_valid = oval_q;
  assign out_data  = data_q;
  assign ack_valid = ackv_q;
  assign ack_seq   = acks_q;
endmodule

// File: rtl/e2e_flit_guard.sv
module e2e_flit_guard #(
  parameter int DATA_W  = 128,
  parameter int ID_W    = 6,
  parameter int NODE_ID = 5,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_in_valid,
  output logic              src_in_ready,
  input  logic [DATA_W-1:0] src_in_data,
  input  logic [ID_W-1:0]   src_in_dest,
  output logic              net_tx_valid,
  input  logic              net_tx_ready,
  output logic [DATA_W-1:0] net_tx_data,
  output logic [7:0]        net_tx_crc,
  output logic              net_tx_seq,
  input  logic              ack_in_valid,
  input  logic              ack_in_seq,
  output logic              vraise_req,
  output logic [ID_W-1:0]   vraise_src,
  output logic [ID_W-1:0]   vraise_dst,
  input  logic              vraise_ack,
  input  logic              net_rx_valid,
  output logic              net_rx_ready,
  input  logic [DATA_W-1:0] net_rx_data,
  input  logic [7:0]        net_rx_crc,
  input  logic              net_rx_seq,
  output logic              dst_out_valid,
  input  logic              dst_out_ready,
  output logic [DATA_W-1:0] dst_out_data,
  output logic              ack_out_valid,
  output logic              ack_out_seq
);
  logic rst_n_s;

  e2e_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  e2e_sender #(
    .DATA_W(DATA_W), .ID_W(ID_W), .NODE_ID(NODE_ID), .TIMEOUT(TIMEOUT)
  ) u_tx (
    .clk(clk), .rst_n(rst_n_s),
    .in_valid(src_in_valid), .in_ready(src_in_ready),
    .in_data(src_in_data), .in_dest(src_in_dest),
    .tx_valid(net_tx_valid), .tx_ready(net_tx_ready),
    .tx_data(net_tx_data), .tx_crc(net_tx_crc), .tx_seq(net_tx_seq),
    .ack_valid(ack_in_valid), .ack_seq(ack_in_seq),
    .raise_req(vraise_req), .raise_src(vraise_src),
    .raise_dst(vraise_dst), .raise_ack(vraise_ack)
  );

  e2e_receiver #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s),
    .rx_valid(net_rx_valid), .rx_ready(net_rx_ready),
    .rx_data(net_rx_data), .rx_crc(net_rx_crc), .rx_seq(net_rx_seq),
    .out_valid(dst_out_valid), .out_ready(dst_out_ready),
    .out_data(dst_out_data),
    .ack_valid(ack_out_valid), .ack_seq(ack_out_seq)
  );
endmodule

// File: rtl/e2e_guard_chk.sv
module e2e_guard_chk #(
  parameter int DATA_W = 128,
  parameter int ID_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_in_valid,
  input logic              src_in_ready,
  input logic              net_tx_valid,
  input logic              net_tx_ready,
  input logic [DATA_W-1:0] net_tx_data,
  input logic [7:0]        net_tx_crc,
  input logic              vraise_req,
  input logic              vraise_ack,
  input logic [ID_W-1:0]   vraise_dst,
  input logic              net_rx_valid,
  input logic              net_rx_ready,
  input logic [DATA_W-1:0] net_rx_data,
  input logic [7:0]        net_rx_crc,
  input logic              ack_out_valid,
  input logic              dst_out_valid,
  input logic              dst_out_ready,
  input logic [DATA_W-1:0] dst_out_data
);
  logic [7:0] tx_crc_ref, rx_crc_ref;

  e2e_crc8 #(.DATA_W(DATA_W)) u_tx_ref (.data(net_tx_data), .crc(tx_crc_ref));
  e2e_crc8 #(.DATA_W(DATA_W)) u_rx_ref (.data(net_rx_data), .crc(rx_crc_ref));

  // R1
  always_comb begin
    if (rst_n && net_tx_valid) begin
      tx_crc_match_chk: assert (net_tx_crc == tx_crc_ref);
    end
  end

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_in_valid && src_in_ready |=> !src_in_ready);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && !net_tx_ready |=> net_tx_valid && $stable(net_tx_data) && $stable(net_tx_crc));

  // R6
  raise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vraise_req && !vraise_ack |=> vraise_req && $stable(vraise_dst));

  // R6
  resend_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vraise_req && vraise_ack |=> net_tx_valid && !vraise_req);

  // R7
  bad_crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_rx_valid && net_rx_ready && (rx_crc_ref != net_rx_crc) |=> !ack_out_valid && !dst_out_valid);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_out_valid && !dst_out_ready |=> dst_out_valid && !net_rx_ready && $stable(dst_out_data));
endmodule

bind e2e_flit_guard e2e_guard_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_guard_chk (.*);

// File: tb/tb_e2e_flit_guard.sv
`timescale 1ns/1ps
module tb_e2e_flit_guard;
  localparam int DW  = 128;
  localparam int IW  = 6;
  localparam int NID = 5;
  localparam int TMO = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n;
  logic src_in_valid, src_in_ready;
  logic [DW-1:0] src_in_data;
  logic [IW-1:0] src_in_dest;
  logic net_tx_valid, net_tx_ready, net_tx_seq;
  logic [DW-1:0] net_tx_data;
  logic [7:0] net_tx_crc;
  logic ack_in_valid, ack_in_seq;
  logic vraise_req, vraise_ack;
  logic [IW-1:0] vraise_src, vraise_dst;
  logic net_rx_valid, net_rx_ready, net_rx_seq;
  logic [DW-1:0] net_rx_data;
  logic [7:0] net_rx_crc;
  logic dst_out_valid, dst_out_ready;
  logic [DW-1:0] dst_out_data;
  logic ack_out_valid, ack_out_seq;

  e2e_flit_guard #(.DATA_W(DW), .ID_W(IW), .NODE_ID(NID), .TIMEOUT(TMO)) dut (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  function automatic logic [7:0] ref_crc(input logic [DW-1:0] d);
    logic [DW+7:0] r;
    r = {d, 8'h00};
    for (int i = DW + 7; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h19B;
    return r[7:0];
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_ph;      // 0 idle, 1 offering, 2 waiting, 3 asking for voltage
  int            m_tmr;
  bit            m_seq, m_exp, m_ackv, m_acks;
  logic [DW-1:0] m_data;
  logic [IW-1:0] m_dest;
  logic [DW-1:0] dq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_tmr = 0; m_seq = 0; m_exp = 0; m_ackv = 0; m_acks = 0;
      dq.delete();
    end else begin
      bit take;
      take = net_rx_valid && (dq.size() == 0);
      if (dq.size() > 0 && dst_out_ready) void'(dq.pop_front());
      m_ackv = 0;
      if (take && ref_crc(net_rx_data) == net_rx_crc) begin
        m_ackv = 1;
        m_acks = net_rx_seq;
        if (net_rx_seq == m_exp) begin
          dq.push_back(net_rx_data);
          m_exp = ~m_exp;
        end
      end
      case (m_ph)
        0: if (src_in_valid) begin m_data = src_in_data; m_dest = src_in_dest; m_ph = 1; end
        1: if (net_tx_ready) begin m_ph = 2; m_tmr = 0; end
        2: if (ack_in_valid && ack_in_seq == m_seq) begin m_ph = 0; m_seq = ~m_seq; end
           else if (m_tmr == TMO - 1) m_ph = 3;
           else m_tmr++;
        default: if (vraise_ack) m_ph = 1;
      endcase
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (rst_n === 1'b1) begin
      chk("R2 model src_in_ready", src_in_ready, m_ph == 0);
      chk("R3 model net_tx_valid", net_tx_valid, m_ph == 1);
      if (m_ph == 1) begin
        chk("R3 model net_tx_data", net_tx_data, m_data);
        chk("R1 model net_tx_crc", net_tx_crc, ref_crc(m_data));
        chk("R4 model net_tx_seq", net_tx_seq, m_seq);
      end
      chk("R5 model vraise_req", vraise_req, m_ph == 3);
      if (m_ph == 3) chk("R5 model vraise_dst", vraise_dst, m_dest);
      chk("R8 model ack_out_valid", ack_out_valid, m_ackv);
      if (m_ackv) chk("R8 model ack_out_seq", ack_out_seq, m_acks);
      chk("R8 model dst_out_valid", dst_out_valid, dq.size() > 0);
      if (dq.size() > 0) chk("R8 model dst_out_data", dst_out_data, dq[0]);
      chk("R10 model net_rx_ready", net_rx_ready, dq.size() == 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [DW-1:0] cap_data;
  logic [7:0]    cap_crc;
  logic          cap_seq;

  task automatic tick(); @(negedge clk); endtask

  task automatic offer(input logic [DW-1:0] d, input logic [IW-1:0] dst);
    src_in_valid = 1'b1; src_in_data = d; src_in_dest = dst;
    tick();
    src_in_valid = 1'b0;
  endtask

  task automatic take_tx();
    cap_data = net_tx_data; cap_crc = net_tx_crc; cap_seq = net_tx_seq;
    net_tx_ready = 1'b1;
    tick();
    net_tx_ready = 1'b0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d, input logic [7:0] c, input logic s);
    net_rx_valid = 1'b1; net_rx_data = d; net_rx_crc = c; net_rx_seq = s;
    tick();
    net_rx_valid = 1'b0;
  endtask

  task automatic give_ack(input logic s);
    ack_in_valid = 1'b1; ack_in_seq = s;
    tick();
    ack_in_valid = 1'b0;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 1'b0;
    src_in_valid = 0; src_in_data = '0; src_in_dest = '0;
    net_tx_ready = 0; ack_in_valid = 0; ack_in_seq = 0; vraise_ack = 0;
    net_rx_valid = 0; net_rx_data = '0; net_rx_crc = '0; net_rx_seq = 0;
    dst_out_ready = 0;
    repeat (3) tick();
    chk("R11 reset src_in_ready", src_in_ready, 1'b1);
    chk("R11 reset net_tx_valid", net_tx_valid, 1'b0);
    chk("R11 reset vraise_req", vraise_req, 1'b0);
    chk("R11 reset dst_out_valid", dst_out_valid, 1'b0);
    chk("R11 reset ack_out_valid", ack_out_valid, 1'b0);
    chk("R11 reset net_rx_ready", net_rx_ready, 1'b1);
    rst_n = 1'b1;
    repeat (3) tick();

    // flit 1: data 0x1, held by the network for two cycles
    offer(128'h1, 6'd3);
    chk("R2 busy after accept", src_in_ready, 1'b0);
    chk("R1 crc of 0x1", net_tx_crc, 8'h9B);
    chk("R4 first tag", net_tx_seq, 1'b0);
    repeat (2) tick();
    chk("R3 still offered", net_tx_valid, 1'b1);
    chk("R3 data held", net_tx_data, 128'h1);
    take_tx();
    push_rx(cap_data, cap_crc, cap_seq);
    chk("R8 delivered", dst_out_valid, 1'b1);
    chk("R8 delivered data", dst_out_data, 128'h1);
    chk("R8 ack pulse", ack_out_valid, 1'b1);
    chk("R8 ack tag", ack_out_seq, 1'b0);
    chk("R10 rx stalled", net_rx_ready, 1'b0);
    tick();
    chk("R8 ack one cycle", ack_out_valid, 1'b0);
    chk("R10 held", dst_out_valid, 1'b1);
    dst_out_ready = 1'b1;
    tick();
    chk("R10 released", net_rx_ready, 1'b1);
    give_ack(1'b1);
    chk("R4 wrong tag ignored", src_in_ready, 1'b0);
    give_ack(1'b0);
    chk("R2 free after ack", src_in_ready, 1'b1);

    // flit 2: data 0x0, corrupted on the way, then timeout path
    offer(128'h0, 6'd9);
    chk("R1 crc of 0x0", net_tx_crc, 8'h00);
    chk("R4 tag inverted", net_tx_seq, 1'b1);
    take_tx();
    src_in_valid = 1'b1; src_in_data = {DW{1'b1}};
    push_rx(cap_data ^ (128'h1 << 77), cap_crc, cap_seq);
    src_in_valid = 1'b0;
    chk("R7 no ack on bad crc", ack_out_valid, 1'b0);
    chk("R7 no delivery on bad crc", dst_out_valid, 1'b0);
    chk("R2 second flit refused", net_tx_valid, 1'b0);
    repeat (TMO - 2) tick();
    chk("R5 not yet raised", vraise_req, 1'b0);
    tick();
    chk("R5 raised at timeout", vraise_req, 1'b1);
    chk("R5 source id", vraise_src, 6'(NID));
    chk("R5 destination id", vraise_dst, 6'd9);
    repeat (3) tick();
    chk("R6 request held", vraise_req, 1'b1);
    vraise_ack = 1'b1;
    tick();
    vraise_ack = 1'b0;
    chk("R6 request dropped", vraise_req, 1'b0);
    chk("R6 resend offered", net_tx_valid, 1'b1);
    chk("R6 resend data", net_tx_data, 128'h0);

    // resend arrives intact, but its acknowledgement is lost
    take_tx();
    push_rx(cap_data, cap_crc, cap_seq);
    chk("R8 resend delivered", dst_out_valid, 1'b1);
    chk("R8 resend ack tag", ack_out_seq, 1'b1);
    repeat (TMO - 2) tick();
    chk("R6 timer restarted, not yet", vraise_req, 1'b0);
    tick();
    chk("R6 timer restarted, raised", vraise_req, 1'b1);
    vraise_ack = 1'b1;
    tick();
    vraise_ack = 1'b0;
    take_tx();
    push_rx(cap_data, cap_crc, cap_seq);
    chk("R9 duplicate acked", ack_out_valid, 1'b1);
    chk("R9 duplicate tag", ack_out_seq, 1'b1);
    chk("R9 duplicate not delivered", dst_out_valid, 1'b0);
    give_ack(1'b1);
    chk("R2 free after second ack", src_in_ready, 1'b1);

    // flit 3: mixed pattern, tag wraps back to 0
    offer(128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3, 6'd63);
    chk("R4 tag wraps", net_tx_seq, 1'b0);
    chk("R1 crc of pattern", net_tx_crc, ref_crc(128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3));
    take_tx();
    push_rx(cap_data, cap_crc, cap_seq);
    chk("R8 pattern delivered", dst_out_data, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3);
    give_ack(1'b0);
    repeat (4) tick();
    chk("R2 idle at end", src_in_ready, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule